// File: doc/BRIEF.md
# Shared SRAM Port Arbiter

This block lets several client modules share one pipelined synchronous SRAM. Each client brings its own request, grant, read/write select, address and write data. It gets its own read-valid strobe from a read-data bus that all clients share. A client that wins the port keeps it for as long as it holds its request high, so it can issue a run of reads and writes back to back. The arbiter may withdraw the grant when a more urgent client is waiting. The client then finishes what it is doing and lowers its request.

Commands from the current owner go into two fixed-latency pipelines. A read returns its word six cycles after it is issued. A write lands in the storage array five cycles after it is issued. The storage is an internal array, so the block stands alone. Fairness is not enforced here. The only time limit on ownership is the minimum hold time that applies before a grant may be withdrawn.

Top module: `sram_arbiter`

## Requirements
- R1: `gnt` has at most one bit set. A grant goes only to a client whose request was high in the cycle before. When the port is free, a lone request is granted in the next cycle.
- R2: When several clients request in the same cycle while the port is free, the one with the lowest index is granted.
- R3: A granted client keeps its grant for as long as its request stays high and no client with a lower index is requesting. Requests from clients with a higher index never take the grant away.
- R4: The grant is withdrawn only when two things both hold. The owner has been granted for at least `HOLD_MIN` cycles (16 by default), and a client with a lower index is requesting. `gnt` falls in the cycle after the owner's `HOLD_MIN`-th granted cycle. Until the owner lowers its request it still owns the port, and its commands are still carried out.
- R5: After the owner lowers its request, `gnt` is all zero for exactly one cycle. A new grant may appear in the cycle after that.
- R6: A read is a cycle in which the owner holds its request high with `rw` = 1. `rvalid` for that client is high, and `rdata` carries the word, six cycles after the issue cycle.
- R7: A write is a cycle in which the owner holds its request high with `rw` = 0. The array holds the new word from five cycles after the issue cycle. A read issued in the cycle right after the write returns the new word.
- R8: Commands from a client that does not own the port have no effect on the array, whatever its `rw` level.
- R9: `rvalid` is asserted only on the bit of the client that issued the read, and on no more than one bit at a time.
- R10: After reset, `gnt` and `rvalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs and outputs are synchronous to its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NCLI | Per-client request; held high to keep ownership |
| rw | input | NCLI | Per-client command select: 1 = read, 0 = write |
| addr | input | NCLI*AW | Per-client word address, client i in bits [i*AW +: AW] |
| wdata | input | NCLI*DW | Per-client write data, client i in bits [i*DW +: DW] |
| gnt | output | NCLI | Per-client grant, one-hot or zero |
| rdata | output | DW | Read data shared by all clients, qualified by `rvalid` |
| rvalid | output | NCLI | Per-client read-data strobe |

## Verification
The bench goes after the boundaries that are easy to get wrong by one cycle. These are the 16-cycle minimum hold before withdrawal, the single idle cycle on hand-over, the six-cycle read return and the five-cycle commit seen by a read issued just after a write. A design that is off by one at any of these moves `gnt` or `rvalid` a cycle early or late, or returns stale data on the read-after-write. Other faults also show up. If the arbiter honours writes from a client without ownership, a later read returns a corrupted word. If it drops a revoked owner's last write, a later read returns stale data. If it steers `rvalid` by grant instead of by issuer, the strobe appears on the wrong client. If it grants by something other than lowest index, the wrong bit of `gnt` rises when requests arrive together.

// File: rtl/sram_arbiter.sv
module sram_arbiter #(
  parameter int NCLI     = 4,
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int RD_LAT   = 6,
  parameter int WR_LAT   = 5,
  parameter int HOLD_MIN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCLI-1:0]      req,
  input  logic [NCLI-1:0]      rw,
  input  logic [NCLI*AW-1:0]   addr,
  input  logic [NCLI*DW-1:0]   wdata,
  output logic [NCLI-1:0]      gnt,
  output logic [DW-1:0]        rdata,
  output logic [NCLI-1:0]      rvalid
);

  localparam int IW    = (NCLI > 1) ? $clog2(NCLI) : 1;
  localparam int HW    = $clog2(HOLD_MIN) + 1;
  localparam int DEPTH = 1 << AW;
  localparam int RLAST = RD_LAT - 2;
  localparam int WLAST = WR_LAT - 2;

  logic          own_v;
  logic [IW-1:0] own;
  logic [HW-1:0] held;
  logic [IW-1:0] win;
  logic          hi_req;
  logic          own_req;
  logic          c_rw;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wd;
  logic          fire;

  always_comb begin
    win = '0;
    for (int i = NCLI - 1; i >= 0; i--)
      if (req[i]) win = IW'(i);
  end

  always_comb begin
    hi_req  = 1'b0;
    own_req = 1'b0;
    c_rw    = 1'b1;
    c_addr  = '0;
    c_wd    = '0;
    for (int i = 0; i < NCLI; i++) begin
      if (IW'(i) < own && req[i]) hi_req = 1'b1;
      if (IW'(i) == own) begin
        own_req = req[i];
        c_rw    = rw[i];
        c_addr  = addr[i*AW +: AW];
        c_wd    = wdata[i*DW +: DW];
      end
    end
  end

  assign fire = own_v & own_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v <= 1'b0;
      own   <= '0;
      held  <= '0;
      gnt   <= '0;
    end else if (own_v) begin
      if (!own_req) begin
        own_v <= 1'b0;
        gnt   <= '0;
      end else begin
        if (gnt[own] && hi_req && held >= HW'(HOLD_MIN - 1)) gnt <= '0;
        if (held < HW'(HOLD_MIN - 1)) held <= held + HW'(1);
      end
    end else if (|req) begin
      own_v    <= 1'b1;
      own      <= win;
      held     <= '0;
      gnt      <= '0;
      gnt[win] <= 1'b1;
    end
  end

  logic          wp_v [0:WLAST];
  logic [AW-1:0] wp_a [0:WLAST];
  logic [DW-1:0] wp_d [0:WLAST];
  logic          rp_v [0:RLAST];
  logic [AW-1:0] rp_a [0:RLAST];
  logic [IW-1:0] rp_c [0:RLAST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= WLAST; k++) wp_v[k] <= 1'b0;
      for (int k = 0; k <= RLAST; k++) rp_v[k] <= 1'b0;
    end else begin
      wp_v[0] <= fire & ~c_rw;
      rp_v[0] <= fire & c_rw;
      for (int k = 1; k <= WLAST; k++) wp_v[k] <= wp_v[k-1];
      for (int k = 1; k <= RLAST; k++) rp_v[k] <= rp_v[k-1];
    end
  end

  always_ff @(posedge clk) begin
    wp_a[0] <= c_addr;
    wp_d[0] <= c_wd;
    rp_a[0] <= c_addr;
    rp_c[0] <= own;
    for (int k = 1; k <= WLAST; k++) begin
      wp_a[k] <= wp_a[k-1];
      wp_d[k] <= wp_d[k-1];
    end
    for (int k = 1; k <= RLAST; k++) begin
      rp_a[k] <= rp_a[k-1];
      rp_c[k] <= rp_c[k-1];
    end
  end

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk)
    if (wp_v[WLAST]) mem[wp_a[WLAST]] <= wp_d[WLAST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= '0;
      rdata  <= '0;
    end else begin
      rvalid <= '0;
      if (rp_v[RLAST]) begin
        rvalid[rp_c[RLAST]] <= 1'b1;
        rdata               <= mem[rp_a[RLAST]];
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R1
  AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) == '0 && gnt != '0) |-> ((gnt & ~$past(req)) == '0)); // R1
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) == '0 && gnt != '0) |-> (((gnt - NCLI'(1)) & $past(req)) == '0)); // R2
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v && own_req && !hi_req) |=> $stable(gnt)); // R3
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v && !own_req) |=> (gnt == '0)); // R5
  AST_RVALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rvalid)); // R9

endmodule

// File: tb/sram_arbiter_bench.sv
module sram_arbiter_bench;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    rw = '1;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0]    gnt;
  logic [DW-1:0]   rdata;
  logic [N-1:0]    rvalid;

  sram_arbiter #(.NCLI(N), .AW(AW), .DW(DW)) u_sram_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .addr(addr),
    .wdata(wdata), .gnt(gnt), .rdata(rdata), .rvalid(rvalid));

  always #4 clk = ~clk;

  int nvec = 0;
  int nfail = 0;
  string cur_tag = "R10";

  // behavioural reference
  int m_own_v, m_own, m_held, edge_n;
  logic [N-1:0] e_gnt, e_rv;
  logic [DW-1:0] e_rd;
  bit e_known;
  logic [DW-1:0] mmem [64];
  bit mknown [64];
  bit rs_v [8]; int rs_a [8]; int rs_c [8];
  bit ws_v [8]; int ws_a [8]; logic [DW-1:0] ws_d [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own_v = 0; m_own = 0; m_held = 0; edge_n = 0;
      e_gnt = '0; e_rv = '0; e_rd = '0; e_known = 0;
      for (int i = 0; i < 8; i++) begin rs_v[i] = 0; ws_v[i] = 0; end
    end else begin
      int s;
      s = edge_n % 8;
      e_rv = '0;
      if (rs_v[s]) begin
        e_rv[rs_c[s]] = 1'b1;
        e_rd = mmem[rs_a[s]];
        e_known = mknown[rs_a[s]];
        rs_v[s] = 0;
      end
      if (ws_v[s]) begin
        mmem[ws_a[s]] = ws_d[s];
        mknown[ws_a[s]] = 1;
        ws_v[s] = 0;
      end
      if (m_own_v != 0 && req[m_own]) begin
        int a;
        a = int'(addr[m_own*AW +: AW]);
        if (rw[m_own]) begin
          rs_v[(edge_n + 5) % 8] = 1; rs_a[(edge_n + 5) % 8] = a; rs_c[(edge_n + 5) % 8] = m_own;
        end else begin
          ws_v[(edge_n + 4) % 8] = 1; ws_a[(edge_n + 4) % 8] = a;
          ws_d[(edge_n + 4) % 8] = wdata[m_own*DW +: DW];
        end
      end
      if (m_own_v != 0) begin
        if (!req[m_own]) begin
          m_own_v = 0; e_gnt = '0;
        end else begin
          bit hi;
          hi = 0;
          for (int j = 0; j < m_own; j++) if (req[j]) hi = 1;
          if (e_gnt[m_own] && hi && m_held >= 15) e_gnt = '0;
          if (m_held < 15) m_held++;
        end
      end else if (req != '0) begin
        int w;
        w = 0;
        for (int j = N - 1; j >= 0; j--) if (req[j]) w = j;
        m_own_v = 1; m_own = w; m_held = 0;
        e_gnt = '0; e_gnt[w] = 1'b1;
      end
      edge_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk(gnt === e_gnt, {cur_tag, " gnt"}, 32'(gnt), 32'(e_gnt));
      chk(rvalid === e_rv, {cur_tag, " rvalid"}, 32'(rvalid), 32'(e_rv));
      if (e_rv != '0 && e_known) chk(rdata === e_rd, {cur_tag, " rdata"}, 32'(rdata), 32'(e_rd));
    end
  endtask

  task automatic drive(input int c, input bit r, input bit rwv, input int a, input int d);
    req[c] = r;
    rw[c] = rwv;
    addr[c*AW +: AW] = AW'(a);
    wdata[c*DW +: DW] = DW'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(gnt == '0, "R10 gnt after reset", 32'(gnt), 0);
    chk(rvalid == '0, "R10 rvalid after reset", 32'(rvalid), 0);

    cur_tag = "R1";
    drive(2, 1, 1, 0, 0);
    tick();
    chk(gnt == 4'b0100, "R1 lone request granted next cycle", 32'(gnt), 32'h4);
    for (int i = 0; i < 8; i++) begin
      drive(2, 1, 0, i, 16'hA0 + i);
      tick();
    end
    cur_tag = "R7";
    drive(2, 1, 0, 10, 16'h5A5A);
    tick();
    drive(2, 1, 1, 10, 0);
    repeat (5) tick();
    chk(rvalid == '0, "R6 no data before six cycles", 32'(rvalid), 0);
    tick();
    chk(rvalid == 4'b0100, "R6 data after six cycles", 32'(rvalid), 32'h4);
    chk(rdata == 16'h5A5A, "R7 read right after write sees new word", 32'(rdata), 32'h5A5A);
    cur_tag = "R6";
    for (int i = 0; i < 8; i++) begin
      drive(2, 1, 1, i, 0);
      tick();
    end

    cur_tag = "R8";
    drive(3, 0, 0, 3, 16'hFFFF);
    drive(1, 0, 0, 4, 16'hEEEE);
    repeat (3) tick();
    drive(3, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    drive(2, 1, 1, 3, 0);
    repeat (6) tick();
    chk(rdata == 16'hA3, "R8 non-owner write ignored", 32'(rdata), 32'hA3);
    chk(rvalid == 4'b0100, "R9 strobe only to issuer", 32'(rvalid), 32'h4);

    cur_tag = "R5";
    drive(2, 0, 1, 0, 0);
    drive(1, 1, 1, 4, 0);
    drive(3, 1, 1, 0, 0);
    tick();
    chk(gnt == '0, "R5 idle cycle on hand-over", 32'(gnt), 0);
    tick();
    chk(gnt == 4'b0010, "R2 lowest index wins", 32'(gnt), 32'h2);

    cur_tag = "R3";
    repeat (30) tick();
    chk(gnt == 4'b0010, "R3 lower-priority request does not revoke", 32'(gnt), 32'h2);
    chk(rdata == 16'hA4, "R8 second non-owner write ignored", 32'(rdata), 32'hA4);

    cur_tag = "R4";
    drive(1, 0, 1, 0, 0);
    tick();
    tick();
    chk(gnt == 4'b1000, "R4 client 3 granted", 32'(gnt), 32'h8);
    repeat (2) tick();
    drive(0, 1, 1, 0, 0);
    repeat (13) tick();
    chk(gnt == 4'b1000, "R4 grant held for minimum", 32'(gnt), 32'h8);
    drive(3, 1, 0, 20, 16'h1234);
    tick();
    chk(gnt == '0, "R4 grant withdrawn after minimum", 32'(gnt), 0);
    drive(3, 0, 1, 0, 0);
    tick();
    chk(gnt == '0, "R5 idle after revoked release", 32'(gnt), 0);
    tick();
    chk(gnt == 4'b0001, "R4 waiting client granted", 32'(gnt), 32'h1);
    drive(0, 1, 1, 20, 0);
    repeat (6) tick();
    chk(rdata == 16'h1234, "R4 revoked owner write completed", 32'(rdata), 32'h1234);
    chk(rvalid == 4'b0001, "R9 strobe to client 0", 32'(rvalid), 32'h1);

    cur_tag = "R9";
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < N; c++) begin
        bit r;
        r = req[c];
        if (!r && ($urandom % 8) == 0) r = 1;
        else if (r && ($urandom % 24) == 0) r = 0;
        drive(c, r, ($urandom % 10) < 6, int'($urandom % 64), int'($urandom % 65536));
      end
      tick();
    end
    req = '0;
    rw = '1;
    repeat (10) tick();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule